// File: doc/BRIEF.md
# UART FIFO Control and DMA Request Logic

This block holds the FIFO control settings for one UART channel and turns the occupancy counts of the channel's transmit and receive FIFOs into DMA request signals and interrupt conditions. A host writes one 8-bit control byte. That byte turns the FIFOs on or off, can flush either FIFO, picks a receive and a transmit trigger threshold, and selects one of two DMA signalling styles. The FIFO storage, the serial shifters and the baud logic sit outside the block. They send the block their current fill counts and take back the flush strobes and the space-available flags.

In single-character signalling, the transmit request `tx_rdy_n` is low while the transmit FIFO is empty. The receive request `rx_rdy_n` is low while at least one received character is waiting. In threshold signalling, `tx_rdy_n` is low while the transmit count is under its threshold. `rx_rdy_n` is low from the moment the receive count reaches its threshold and for as long as the count stays at or above it. Reaching that threshold does not stop reception: the receive FIFO accepts characters until it is full.

When the FIFOs are turned off, each side behaves as a one-entry holding register and single-character signalling applies whatever the mode bit says.

Top module: `uart_fifo_dma_ctl`

## Requirements
- R1: After reset the stored control fields are all zero, so the FIFOs are off and single-character signalling is selected. `tx_rdy_n` and `rx_rdy_n` are high, and `rx_clr` and `tx_clr` are low.
- R2: A write with `cfg_we` high stores the control byte as follows. Bit 0 enables the FIFOs. Bit 3 selects threshold signalling when set. Bits 5:4 pick the transmit threshold: codes 0/1/2/3 give 8/16/32/56. Bits 7:6 pick the receive threshold: codes 0/1/2/3 give 8/16/56/60.
- R3: Writing bit 1 high makes `rx_clr` high for exactly the one cycle after the write cycle, and writing bit 2 high does the same for `tx_clr`. Neither bit is stored.
- R4: In single-character signalling, `tx_rdy_n` is low exactly when `tx_count` was 0 one clock earlier.
- R5: In single-character signalling, `rx_rdy_n` is low exactly when `rx_count` was at least 1 one clock earlier.
- R6: In threshold signalling with the FIFOs on, `tx_rdy_n` is low exactly when `tx_count` was below the transmit threshold one clock earlier.
- R7: In threshold signalling with the FIFOs on, `rx_rdy_n` is low exactly when `rx_count` was at or above the receive threshold one clock earlier.
- R8: With bit 0 clear, the effective depth is 1 and single-character signalling is used even if bit 3 is set. In this state `rx_space` and `tx_space` are high only when the corresponding count is 0.
- R9: With the FIFOs on, `rx_space` and `tx_space` are high while the count is below 128, whatever the threshold.
- R10: `rx_irq` is high in the same cycle that `rx_count` is at or above the receive threshold. `tx_irq` is high in the same cycle that `tx_count` is below the transmit threshold. With the FIFOs off, both thresholds are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| tx_count | input | 8 | Transmit FIFO fill count |
| rx_count | input | 8 | Receive FIFO fill count |
| rx_clr | output | 1 | One-cycle receive FIFO flush |
| tx_clr | output | 1 | One-cycle transmit FIFO flush |
| rx_space | output | 1 | Receive FIFO can take another character |
| tx_space | output | 1 | Transmit FIFO can take another character |
| rx_irq | output | 1 | Receive threshold interrupt condition |
| tx_irq | output | 1 | Transmit threshold interrupt condition |
| tx_rdy_n | output | 1 | Transmit DMA request, active low, registered |
| rx_rdy_n | output | 1 | Receive DMA request, active low, registered |

## Verification
The assertions check on every cycle that each DMA request follows the previous cycle's count in the signalling style then in force. In threshold mode, the request must equal the registered inverse of the interrupt condition. They also check that flush pulses come only after writes, and that space-available follows the one-entry rule when the FIFOs are off. The threshold values behind each code, the exact set of counts at which each output switches, and the reset values can only be shown by the bench. The bench sweeps every count against every mode, enable setting and threshold code.

// File: rtl/uart_fifo_dma_ctl.sv
module uart_fifo_dma_ctl #(
  parameter int DEPTH = 128,
  parameter int RX_T0 = 8,
  parameter int RX_T1 = 16,
  parameter int RX_T2 = 56,
  parameter int RX_T3 = 60,
  parameter int TX_T0 = 8,
  parameter int TX_T1 = 16,
  parameter int TX_T2 = 32,
  parameter int TX_T3 = 56,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  output logic          rx_clr,
  output logic          tx_clr,
  output logic          rx_space,
  output logic          tx_space,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          tx_rdy_n,
  output logic          rx_rdy_n
);

  logic          fifo_en, dma_mode;
  logic [1:0]    rx_code, tx_code;
  logic [CW-1:0] rx_trig, tx_trig, rx_lvl, tx_lvl, depth_eff;
  logic          lvl_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      rx_code  <= 2'd0;
      tx_code  <= 2'd0;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
    end else begin
      rx_clr <= cfg_we & cfg_wdata[1];
      tx_clr <= cfg_we & cfg_wdata[2];
      if (cfg_we) begin
        fifo_en  <= cfg_wdata[0];
        dma_mode <= cfg_wdata[3];
        tx_code  <= cfg_wdata[5:4];
        rx_code  <= cfg_wdata[7:6];
      end
    end
  end

  always_comb begin
    case (rx_code)
      2'd0:    rx_trig = CW'(RX_T0);
      2'd1:    rx_trig = CW'(RX_T1);
      2'd2:    rx_trig = CW'(RX_T2);
      default: rx_trig = CW'(RX_T3);
    endcase
    case (tx_code)
      2'd0:    tx_trig = CW'(TX_T0);
      2'd1:    tx_trig = CW'(TX_T1);
      2'd2:    tx_trig = CW'(TX_T2);
      default: tx_trig = CW'(TX_T3);
    endcase
  end

  assign rx_lvl    = fifo_en ? rx_trig : CW'(1);
  assign tx_lvl    = fifo_en ? tx_trig : CW'(1);
  assign depth_eff = fifo_en ? CW'(DEPTH) : CW'(1);
  assign lvl_mode  = fifo_en & dma_mode;

  assign rx_irq   = rx_count >= rx_lvl;
  assign tx_irq   = tx_count <  tx_lvl;
  assign rx_space = rx_count <  depth_eff;
  assign tx_space = tx_count <  depth_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rdy_n <= 1'b1;
      rx_rdy_n <= 1'b1;
    end else begin
      tx_rdy_n <= !(lvl_mode ? tx_irq : (tx_count == '0));
      rx_rdy_n <= !(lvl_mode ? rx_irq : (rx_count != '0));
    end
  end

endmodule

module uart_fifo_dma_ctl_chk #(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rx_clr,
  input logic          tx_clr,
  input logic          rx_space,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          tx_rdy_n,
  input logic          rx_rdy_n,
  input logic          fifo_en,
  input logic          dma_mode
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_clr_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (rx_clr || tx_clr) |-> $past(cfg_we));

  p_txrdy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!(fifo_en && dma_mode)) |-> tx_rdy_n == ($past(tx_count) != '0));

  p_rxrdy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!(fifo_en && dma_mode)) |-> rx_rdy_n == ($past(rx_count) == '0));

  p_txrdy_thresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(fifo_en && dma_mode) |-> tx_rdy_n == !$past(tx_irq));

  p_rxrdy_thresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(fifo_en && dma_mode) |-> rx_rdy_n == !$past(rx_irq));

  p_one_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> rx_space == (rx_count == '0));

  p_fill_past_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && rx_irq && (rx_count < CW'(DEPTH)) |-> rx_space);

endmodule

bind uart_fifo_dma_ctl uart_fifo_dma_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tx_count(tx_count),
  .rx_count(rx_count), .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_space(rx_space),
  .rx_irq(rx_irq), .tx_irq(tx_irq), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n),
  .fifo_en(fifo_en), .dma_mode(dma_mode)
);

// File: tb/uart_fifo_dma_ctl_tb.sv
module uart_fifo_dma_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] tx_count = 8'd0;
  logic [7:0] rx_count = 8'd0;
  logic rx_clr, tx_clr, rx_space, tx_space, rx_irq, tx_irq, tx_rdy_n, rx_rdy_n;

  int checks = 0;
  int fails = 0;
  int rx_tab [4] = '{8, 16, 56, 60};
  int tx_tab [4] = '{8, 16, 32, 56};

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_dma_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_count(tx_count), .rx_count(rx_count), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .rx_space(rx_space), .tx_space(tx_space), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b (rx=%0d tx=%0d)",
               req, $time, act, exp, rx_count, tx_count);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(posedge clk); #1;
    chk("R3 rx_clr pulse", rx_clr, d[1]);
    chk("R3 tx_clr pulse", tx_clr, d[2]);
    @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk); #1;
    chk("R3 rx_clr ends", rx_clr, 1'b0);
    chk("R3 tx_clr ends", tx_clr, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual expired expected done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tx_rdy_n reset", tx_rdy_n, 1'b1);
    chk("R1 rx_rdy_n reset", rx_rdy_n, 1'b1);
    chk("R1 rx_clr reset", rx_clr, 1'b0);
    chk("R1 tx_clr reset", tx_clr, 1'b0);
    chk("R1 fifo off: tx_irq", tx_irq, 1'b1);
    chk("R1 fifo off: rx_irq", rx_irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 idle counts 0: tx_rdy_n low", tx_rdy_n, 1'b0);
    chk("R1 idle counts 0: rx_rdy_n high", rx_rdy_n, 1'b1);

    wr(8'h06);
    wr(8'h02);
    wr(8'h04);

    for (int en = 0; en < 2; en++)
      for (int md = 0; md < 2; md++)
        for (int code = 0; code < 4; code++) begin
          int rlv, tlv, dep;
          logic thr;
          wr({code[1:0], code[1:0], md[0], 2'b00, en[0]});
          rlv = en ? rx_tab[code] : 1;
          tlv = en ? tx_tab[code] : 1;
          dep = en ? DEPTH : 1;
          thr = (en == 1) && (md == 1);
          for (int c = 0; c <= DEPTH; c++) begin
            int t;
            t = (c * 37) % (DEPTH + 1);
            @(negedge clk);
            rx_count = 8'(c);
            tx_count = 8'(t);
            #1;
            chk("R10 rx_irq", rx_irq, c >= rlv);
            chk("R10 tx_irq", tx_irq, t < tlv);
            chk(en ? "R9 rx_space" : "R8 rx_space", rx_space, c < dep);
            chk(en ? "R9 tx_space" : "R8 tx_space", tx_space, t < dep);
            @(posedge clk); #1;
            if (thr) begin
              chk("R6 tx_rdy_n threshold", tx_rdy_n, !(t < tlv));
              chk("R7 rx_rdy_n threshold", rx_rdy_n, !(c >= rlv));
            end else begin
              chk(en ? "R4 tx_rdy_n single" : "R8 tx_rdy_n forced single", tx_rdy_n, t != 0);
              chk(en ? "R5 rx_rdy_n single" : "R8 rx_rdy_n forced single", rx_rdy_n, c == 0);
            end
          end
        end

    wr(8'hF9);
    @(negedge clk);
    rx_count = 8'd59;
    tx_count = 8'd56;
    #1;
    chk("R2 rx code 3 = 60 below", rx_irq, 1'b0);
    chk("R2 tx code 3 = 56 at", tx_irq, 1'b0);
    @(negedge clk);
    rx_count = 8'd60;
    tx_count = 8'd55;
    #1;
    chk("R2 rx code 3 = 60 at", rx_irq, 1'b1);
    chk("R2 tx code 3 = 56 below", tx_irq, 1'b1);
    @(posedge clk); #1;
    chk("R7 rx_rdy_n at 60", rx_rdy_n, 1'b0);
    chk("R6 tx_rdy_n at 55", tx_rdy_n, 1'b0);
    report();
  end
endmodule